// File: doc/BRIEF.md
# Selectable-Polynomial Serial CRC Engine

This block computes a cyclic redundancy check one bit at a time. Each falling clock edge moves one serial data bit into a 16-bit feedback shift register. A 3-bit select input picks one of eight generator polynomials at run time. Polynomials of degree below 16 sit right-justified in the low end of the register. Two synchronous controls start each computation from a known state: one loads all zeros and the other loads all ones.

For generation, the message is clocked in with feedback enabled. Feedback is then switched off, and the stored remainder shifts out on the serial output, most significant check bit first, to be appended after the message. For checking, the message and the received check bits both enter the data input with feedback enabled. The block only watches the stream. Its error flag is high whenever the register holds a nonzero remainder within the selected degree.

Top module: `crc_serial_engine`

## Requirements
- R1: While the active-low reset `rst_n` is low, the register is all zeros, so `dout` and `crc_err` are both low.
- R2: `poly_sel` picks the polynomial as follows: 0 x^16+x^15+x^2+1, 1 x^16+x^14+x+1, 2 x^16+x^12+x^5+1, 3 x^16+x^11+x^4+1, 4 x^12+x^11+x^3+x^2+x+1, 5 x^8+1, 6 x^8+x^2+x+1, 7 x^7+x^3+1. Data is taken MSB first, and the feedback bit is `din` XOR the register's top bit.
- R3: For a polynomial of degree d, only register bits d-1..0 are used and `dout` shows bit d-1. The bits above d-1 are zero after any shift.
- R4: `sync_clear` high at a falling edge zeroes the register, and it wins over `sync_preset`.
- R5: `sync_preset` high with `sync_clear` low at a falling edge sets every register bit to one.
- R6: With `feedback_en` low, the register shifts toward its top bit with zero fill and `din` has no effect. `dout` therefore gives the stored check bits MSB first, and the register is empty after d shifts.
- R7: `crc_err` is high exactly when the register bits within the selected degree are nonzero.
- R8: A message followed by its own check word, all clocked in with feedback enabled, leaves `crc_err` low. This holds from either start state. One corrupted message bit drives `crc_err` high.
- R9: The register changes only on the falling edge of `clk`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the register advances on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_clear | input | 1 | Synchronous load of all zeros (highest priority) |
| sync_preset | input | 1 | Synchronous load of all ones |
| feedback_en | input | 1 | High: absorb data with feedback; low: shift out check bits |
| poly_sel | input | 3 | Polynomial select |
| din | input | 1 | Serial data / received check bits |
| dout | output | 1 | Top bit of the active register field |
| crc_err | output | 1 | Nonzero remainder within the selected degree |

## Verification
The ASCII string "123456789" is run through three 16-bit selections and both start states. The results are compared against the well-known check values 0x29B1, 0x31C3 and 0xFEE8, which separates the polynomial tap choice from the preset/clear handling. Every selection then generates a check word and verifies it in check mode. The same selection with one message bit flipped must raise the error flag, and an empty register must follow shift-out; this exposes right-justification mistakes for the degree 12, 8 and 7 cases. Two-byte parity on the x^8+1 selection, shift-out with `din` held high, clear and preset raised together, and a half-cycle probe between edges check the remaining controls, while a behavioural model is compared on every clock.

// File: rtl/crc_sel_pkg.sv
package crc_sel_pkg;
  localparam int CRC_W = 16;
  localparam int IDX_W = $clog2(CRC_W);

  typedef enum logic [2:0] {
    SEL_C16    = 3'd0,
    SEL_C16R   = 3'd1,
    SEL_CCITT  = 3'd2,
    SEL_CCITTR = 3'd3,
    SEL_C12    = 3'd4,
    SEL_PAR8   = 3'd5,
    SEL_C8     = 3'd6,
    SEL_C7     = 3'd7
  } poly_sel_e;

  // tap vector without the implicit leading term
  function automatic logic [CRC_W-1:0] poly_taps(poly_sel_e s);
    case (s)
      SEL_C16:    return 16'h8005;
      SEL_C16R:   return 16'h4003;
      SEL_CCITT:  return 16'h1021;
      SEL_CCITTR: return 16'h0811;
      SEL_C12:    return 16'h080F;
      SEL_PAR8:   return 16'h0001;
      SEL_C8:     return 16'h0007;
      default:    return 16'h0009;
    endcase
  endfunction

  function automatic logic [IDX_W:0] poly_degree(poly_sel_e s);
    case (s)
      SEL_C12:           return (IDX_W+1)'(12);
      SEL_PAR8, SEL_C8:  return (IDX_W+1)'(8);
      SEL_C7:            return (IDX_W+1)'(7);
      default:           return (IDX_W+1)'(16);
    endcase
  endfunction

  function automatic logic [CRC_W-1:0] poly_mask(poly_sel_e s);
    logic [CRC_W-1:0] m;
    for (int i = 0; i < CRC_W; i++) m[i] = (i < int'(poly_degree(s)));
    return m;
  endfunction
endpackage

// File: rtl/crc_poly_decode.sv
module crc_poly_decode
  import crc_sel_pkg::*;
#(
  parameter int W  = CRC_W,
  parameter int IW = IDX_W
) (
  input  poly_sel_e       sel,
  output logic [W-1:0]    taps,
  output logic [W-1:0]    field_mask,
  output logic [IW-1:0]   top_idx
);
  logic [IW:0] degree;

  always_comb begin
    taps    = poly_taps(sel);
    degree  = poly_degree(sel);
    top_idx = IW'(degree - 1'b1);
  end

  for (genvar g = 0; g < W; g++) begin : g_mask
    assign field_mask[g] = (int'(degree) > g);
  end
endmodule

// File: rtl/crc_shift_core.sv
module crc_shift_core #(
  parameter int W  = 16,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          pre,
  input  logic          fb_en,
  input  logic          din,
  input  logic [W-1:0]  taps,
  input  logic [W-1:0]  field_mask,
  input  logic [IW-1:0] top_idx,
  output logic [W-1:0]  state_q
);
  logic [W-1:0] state_d;
  logic [W-1:0] shifted;
  logic         top_bit;
  logic         fb;

  always_comb begin
    top_bit = state_q[top_idx];
    fb      = fb_en & (din ^ top_bit);
    shifted = {state_q[W-2:0], 1'b0} & field_mask;
    if (clr)
      state_d = '0;
    else if (pre)
      state_d = '1;
    else
      state_d = shifted ^ (taps & {W{fb}});
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)
      state_q <= '0;
    else
      state_q <= state_d;
  end
endmodule

// File: rtl/crc_remainder_flag.sv
module crc_remainder_flag #(
  parameter int W  = 16,
  parameter int IW = 4
) (
  input  logic [W-1:0]  state_q,
  input  logic [W-1:0]  field_mask,
  input  logic [IW-1:0] top_idx,
  output logic          dout,
  output logic          crc_err
);
  always_comb begin
    dout    = state_q[top_idx];
    crc_err = |(state_q & field_mask);
  end
endmodule

// File: rtl/crc_serial_engine.sv
module crc_serial_engine
  import crc_sel_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sync_clear,
  input  logic       sync_preset,
  input  logic       feedback_en,
  input  logic [2:0] poly_sel,
  input  logic       din,
  output logic       dout,
  output logic       crc_err
);
  logic [CRC_W-1:0] taps;
  logic [CRC_W-1:0] field_mask;
  logic [IDX_W-1:0] top_idx;
  logic [CRC_W-1:0] state_q;

  crc_poly_decode #(.W(CRC_W), .IW(IDX_W)) u_decode (
    .sel        (poly_sel_e'(poly_sel)),
    .taps       (taps),
    .field_mask (field_mask),
    .top_idx    (top_idx)
  );

  crc_shift_core #(.W(CRC_W), .IW(IDX_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (sync_clear),
    .pre        (sync_preset),
    .fb_en      (feedback_en),
    .din        (din),
    .taps       (taps),
    .field_mask (field_mask),
    .top_idx    (top_idx),
    .state_q    (state_q)
  );

  crc_remainder_flag #(.W(CRC_W), .IW(IDX_W)) u_flag (
    .state_q    (state_q),
    .field_mask (field_mask),
    .top_idx    (top_idx),
    .dout       (dout),
    .crc_err    (crc_err)
  );
endmodule

// File: rtl/crc_serial_engine_chk.sv
module crc_serial_engine_chk
  import crc_sel_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             sync_clear,
  input logic             sync_preset,
  input logic             feedback_en,
  input logic [2:0]       poly_sel,
  input logic             dout,
  input logic             crc_err,
  input logic [CRC_W-1:0] state
);
  // R4
  clear_zero_chk: assert property (@(negedge clk) disable iff (!rst_n)
    sync_clear |=> (state == '0) && !crc_err && !dout);

  // R5
  preset_ones_chk: assert property (@(negedge clk) disable iff (!rst_n)
    (!sync_clear && sync_preset) |=> crc_err && dout);

  // R6
  inhibit_shift_chk: assert property (@(negedge clk) disable iff (!rst_n)
    (!sync_clear && !sync_preset && !feedback_en) |=>
      state == ({$past(state[CRC_W-2:0]), 1'b0} & poly_mask(poly_sel_e'($past(poly_sel)))));

  // R3
  upper_zero_chk: assert property (@(negedge clk) disable iff (!rst_n)
    (!sync_clear && !sync_preset) |=>
      ((state & ~poly_mask(poly_sel_e'($past(poly_sel)))) == '0));
endmodule

bind crc_serial_engine crc_serial_engine_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sync_clear  (sync_clear),
  .sync_preset (sync_preset),
  .feedback_en (feedback_en),
  .poly_sel    (poly_sel),
  .dout        (dout),
  .crc_err     (crc_err),
  .state       (state_q)
);

// File: tb/tb_crc_serial_engine.sv
module tb_crc_serial_engine;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       sync_clear, sync_preset, feedback_en, din;
  logic [2:0] poly_sel;
  logic       dout, crc_err;
  int         checks = 0;
  int         errors = 0;
  int         mrem;

  always #10 clk = ~clk;

  crc_serial_engine dut (
    .clk(clk), .rst_n(rst_n), .sync_clear(sync_clear), .sync_preset(sync_preset),
    .feedback_en(feedback_en), .poly_sel(poly_sel), .din(din),
    .dout(dout), .crc_err(crc_err)
  );

  function automatic int m_deg(int s);
    int d[8] = '{16, 16, 16, 16, 12, 8, 8, 7};
    return d[s];
  endfunction

  function automatic int m_poly(int s);
    int p[8] = '{'h18005, 'h14003, 'h11021, 'h10811, 'h180F, 'h101, 'h107, 'h89};
    return p[s];
  endfunction

  // behavioural reference: polynomial long division, one bit per falling edge
  always @(negedge clk or negedge rst_n) begin
    int d, top;
    if (!rst_n) mrem = 0;
    else if (sync_clear) mrem = 0;
    else if (sync_preset) mrem = 'hFFFF;
    else begin
      d   = m_deg(int'(poly_sel));
      mrem = mrem % (1 << d);
      top = (mrem >> (d - 1)) & 1;
      mrem = mrem * 2;
      if (feedback_en && (top != int'(din))) mrem = mrem ^ m_poly(int'(poly_sel));
      else if (top == 1) mrem = mrem - (1 << d);
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // sample at posedge (between falling edges), compare with model, then drive
  task automatic step(input bit d, input bit fe, input bit c, input bit p,
                      output bit q, output bit e);
    int dg;
    @(posedge clk); #1;
    dg = m_deg(int'(poly_sel));
    q = dout; e = crc_err;
    chk("R2 R7 model dout", int'(dout), (mrem >> (dg - 1)) & 1);
    chk("R7 model crc_err", int'(crc_err), int'((mrem % (1 << dg)) != 0));
    din = d; feedback_en = fe; sync_clear = c; sync_preset = p;
  endtask

  task automatic start(input bit use_preset);
    bit q, e;
    step(1'b0, 1'b1, !use_preset, use_preset, q, e);
  endtask

  task automatic feed_bits(input int val, input int n);
    bit q, e;
    for (int i = n - 1; i >= 0; i--) step(val[i], 1'b1, 1'b0, 1'b0, q, e);
  endtask

  task automatic feed_msg(input bit corrupt);
    string s = "123456789";
    for (int i = 0; i < 9; i++)
      feed_bits(int'(s[i]) ^ ((corrupt && i == 0) ? 1 : 0), 8);
  endtask

  task automatic read_word(input int n, input bit din_val, output int w);
    bit q, e;
    w = 0;
    for (int i = 0; i < n; i++) begin
      step(din_val, 1'b0, 1'b0, 1'b0, q, e);
      w = (w << 1) | int'(q);
    end
  endtask

  initial begin
    #2000000;
    checks++; errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit q, e;
    int w, w2;
    rst_n = 1'b0; sync_clear = 0; sync_preset = 0; feedback_en = 1; din = 0; poly_sel = 3'd2;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset dout", int'(dout), 0);
    chk("R1 reset crc_err", int'(crc_err), 0);
    rst_n = 1'b1;

    // R5: preset state visible, then CCITT over the string from all ones
    start(1'b1);
    step(1'b0, 1'b1, 1'b0, 1'b1, q, e);
    chk("R5 preset dout", int'(q), 1);
    chk("R5 preset crc_err", int'(e), 1);
    feed_msg(1'b0);
    read_word(16, 1'b0, w);
    chk("R2 ccitt preset value", w, 'h29B1);

    // R8: check mode, good then corrupted
    start(1'b1); feed_msg(1'b0); feed_bits('h29B1, 16);
    step(1'b0, 1'b1, 1'b1, 1'b0, q, e);
    chk("R8 good frame crc_err", int'(e), 0);
    start(1'b1); feed_msg(1'b1); feed_bits('h29B1, 16);
    step(1'b0, 1'b1, 1'b1, 1'b0, q, e);
    chk("R8 corrupted frame crc_err", int'(e), 1);

    // R4: clear state, then CCITT and CRC-16 from zero
    step(1'b0, 1'b1, 1'b0, 1'b0, q, e);
    chk("R4 clear crc_err", int'(e), 0);
    feed_msg(1'b0);
    read_word(16, 1'b0, w);
    chk("R2 ccitt clear value", w, 'h31C3);
    poly_sel = 3'd0;
    start(1'b0); feed_msg(1'b0);
    read_word(16, 1'b0, w);
    chk("R2 crc16 clear value", w, 'hFEE8);

    // R2: x^8+1 gives bytewise parity
    poly_sel = 3'd5;
    start(1'b0); feed_bits('hA5, 8); feed_bits('h3C, 8);
    read_word(8, 1'b0, w);
    chk("R2 parity8 value", w, 'h99);

    // every selection, both start states: generate, empty after shift-out, verify
    for (int s = 0; s < 8; s++) begin
      for (int p = 0; p < 2; p++) begin
        poly_sel = 3'(s);
        start(p[0]); feed_msg(1'b0);
        read_word(m_deg(s), 1'b0, w);
        step(1'b0, 1'b1, 1'b0, 1'b0, q, e);
        chk("R3 empty after shift-out dout", int'(q), 0);
        chk("R6 empty after shift-out crc_err", int'(e), 0);
        start(p[0]); feed_msg(1'b0); feed_bits(w, m_deg(s));
        step(1'b0, 1'b1, 1'b1, 1'b0, q, e);
        chk("R8 verify crc_err", int'(e), 0);
        start(p[0]); feed_msg(1'b1); feed_bits(w, m_deg(s));
        step(1'b0, 1'b1, 1'b1, 1'b0, q, e);
        chk("R8 corrupt crc_err", int'(e), 1);
        w2 = w;
      end
    end

    // R6: din ignored while feedback is off
    poly_sel = 3'd2;
    start(1'b1);
    read_word(16, 1'b1, w);
    chk("R6 shift-out with din high", w, 'hFFFF);
    step(1'b0, 1'b1, 1'b0, 1'b0, q, e);
    chk("R6 zero fill crc_err", int'(e), 0);

    // R4: clear beats preset
    start(1'b1);
    step(1'b0, 1'b1, 1'b1, 1'b1, q, e);
    step(1'b0, 1'b1, 1'b1, 1'b0, q, e);
    chk("R4 priority crc_err", int'(e), 0);
    chk("R4 priority dout", int'(q), 0);

    // R9: no change before the falling edge
    @(posedge clk); #1;
    sync_clear = 1'b0; sync_preset = 1'b1;
    #5;
    chk("R9 before falling edge", int'(crc_err), 0);
    @(negedge clk); #1;
    chk("R9 after falling edge", int'(crc_err), 1);
    step(1'b0, 1'b1, 1'b1, 1'b0, q, e);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule